// File: doc/BRIEF.md
# Paged Serial Memory Target with Timed Programming

This block is the target side of an I2C link to a small nonvolatile store of 128 bytes. It follows the two bus lines through synchronizers and finds START and STOP conditions. It answers its own 7-bit device address and sets a location pointer from the word-address byte. It gathers incoming data in a 16-byte staging buffer, and only on STOP does it move that buffer into the storage array, all at once. A fixed-length programming interval follows. For that whole interval the target is deaf to the bus.

A host that has just written waits for the interval by sending START plus a write address over and over until the address is acknowledged. Reads start at the current pointer, so the host first sends a word address with no data and then a repeated START with the read bit set. The host can then read as many bytes as it wants, in order, and it ends the read with a NACK. A write-protect input keeps the array read-only.

Top module: `seeprom_target`

## Requirements
- R1: After a START, the target acknowledges a first byte whose bits [7:1] equal the device address (default 7'h50) and whose bit 0 is the direction (0 write, 1 read). It pulls SDA low during the ninth clock and changes its SDA drive only after a falling edge of SCL.
- R2: If the address in the first byte differs, the target acknowledges nothing, and none of the traffic before the next START or STOP has any effect.
- R3: In a write, the target acknowledges the second byte and loads it into the location pointer, using the low 7 bits. The first data byte is stored at that location.
- R4: The target acknowledges every data byte and then adds one to pointer bits [3:0] only. Bits [6:4] stay fixed, so a write that runs past the last location of a 16-byte page continues at the first location of that page.
- R5: If more than 16 data bytes arrive in one write, the later bytes replace the earlier bytes that were staged for the same locations.
- R6: Staged bytes reach the array only on STOP. On that STOP, busy_o rises 3 clock cycles after SDA rises and stays high for exactly T_PROG cycles. A STOP with nothing staged starts no busy interval.
- R7: While busy_o is high, the target ignores every START and never drives SDA. An address poll is therefore not acknowledged until the interval has ended.
- R8: If wp_i is high at STOP, the array is not changed and no busy interval starts.
- R9: A START or repeated START that arrives before STOP throws away the staged bytes but keeps the pointer.
- R10: In a read, the target sends the byte at the pointer, MSB first, and then adds one to the whole 7-bit pointer, wrapping from 127 to 0. A host ACK asks for the next byte. A host NACK ends the read.
- R11: After reset, busy_o and sda_o are low and every array location holds 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| wp_i | input | 1 | Write protect; high makes the array read-only |
| sda_o | output | 1 | When high, the target pulls the data line low |
| busy_o | output | 1 | High for the whole programming interval |

## Verification
Every bus event is seen two clock cycles after the pin changes, because of the synchronizer. The SDA drive therefore changes 3 cycles after an SCL falling edge, and busy_o rises 3 cycles after the SDA rise of a STOP. The bench holds each SCL phase for 16 cycles and samples acknowledges and read bits in the middle of the high phase, well clear of those delays. The bench records the cycle of every STOP that should start programming. On every falling clock edge it compares busy_o against the window that opens 3 cycles after that STOP and closes T_PROG cycles later.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_ACK_WAIT, ST_ACK_HOLD,
    ST_RD, ST_RD_ACK, ST_RD_ACKS, ST_RD_NEXT, ST_SKIP
  } ctl_state_e;

  typedef struct packed {
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/seeprom_bus_sync.sv
module seeprom_bus_sync
  import seeprom_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  always_comb begin
    ev_o.sda      = sda_s;
    ev_o.scl_rise = scl_s & ~scl_d;
    ev_o.scl_fall = ~scl_s & scl_d;
    // SDA edges with SCL held high on both samples
    ev_o.start    = scl_s & scl_d & sda_d & ~sda_s;
    ev_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
  end
endmodule

// File: rtl/seeprom_page_buf.sv
module seeprom_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DW         = 8,
  localparam int OW        = $clog2(PAGE_BYTES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clear_i,
  input  logic                             wr_i,
  input  logic [OW-1:0]                    idx_i,
  input  logic [DW-1:0]                    data_i,
  output logic [PAGE_BYTES-1:0][DW-1:0]    data_o,
  output logic [PAGE_BYTES-1:0]            valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= '0;
    end else if (clear_i) begin
      valid_o <= '0;
    end else if (wr_i) begin
      data_o[idx_i]  <= data_i;
      valid_o[idx_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/seeprom_array.sv
module seeprom_array #(
  parameter int MEM_DEPTH  = 128,
  parameter int PAGE_BYTES = 16,
  parameter int DW         = 8,
  localparam int AW        = $clog2(MEM_DEPTH),
  localparam int OW        = $clog2(PAGE_BYTES),
  localparam int PW        = AW - OW
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          commit_i,
  input  logic [PW-1:0]                 page_i,
  input  logic [PAGE_BYTES-1:0][DW-1:0] buf_data_i,
  input  logic [PAGE_BYTES-1:0]         buf_valid_i,
  input  logic [AW-1:0]                 rd_addr_i,
  output logic [DW-1:0]                 rd_data_o
);
  logic [DW-1:0] mem [MEM_DEPTH];

  for (genvar a = 0; a < MEM_DEPTH; a++) begin : g_word
    localparam logic [PW-1:0] PG = PW'(a / PAGE_BYTES);
    localparam int            IX = a % PAGE_BYTES;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[a] <= '1;
      else if (commit_i && page_i == PG && buf_valid_i[IX]) mem[a] <= buf_data_i[IX];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/seeprom_prog_timer.sv
module seeprom_prog_timer #(
  parameter int T_PROG = 200,
  localparam int CW    = $clog2(T_PROG + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(T_PROG);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/seeprom_target.sv
module seeprom_target
  import seeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         MEM_DEPTH   = 128,
  parameter int         PAGE_BYTES  = 16,
  parameter int         T_PROG      = 200,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_o,
  output logic busy_o
);
  localparam int DW = 8;
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int PW = AW - OW;

  bus_ev_t     bus_ev;
  ctl_state_e  state_q, nxt_q;
  logic [2:0]  bit_cnt_q;
  logic [6:0]  shreg_q;
  logic [7:0]  tx_q;
  logic [AW-1:0] ptr_q;
  logic        sda_oe_q;

  logic [7:0]  byte_now;
  logic        byte_done, buf_wr, buf_clear, commit;
  logic [PAGE_BYTES-1:0][DW-1:0] buf_data;
  logic [PAGE_BYTES-1:0]         buf_valid;
  logic [DW-1:0]                 rd_data;

  seeprom_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i, .ev_o(bus_ev)
  );

  assign byte_now  = {shreg_q, bus_ev.sda};
  assign byte_done = bus_ev.scl_rise && (bit_cnt_q == 3'd7);
  assign buf_wr    = (state_q == ST_WDATA) && byte_done && !bus_ev.start && !bus_ev.stop;
  assign buf_clear = bus_ev.start | bus_ev.stop;
  assign commit    = bus_ev.stop && (|buf_valid) && !wp_i && !busy_o;

  seeprom_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DW(DW)) u_buf (
    .clk_i, .rst_ni,
    .clear_i (buf_clear),
    .wr_i    (buf_wr),
    .idx_i   (ptr_q[OW-1:0]),
    .data_i  (byte_now),
    .data_o  (buf_data),
    .valid_o (buf_valid)
  );

  seeprom_array #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES), .DW(DW)) u_mem (
    .clk_i, .rst_ni,
    .commit_i    (commit),
    .page_i      (ptr_q[AW-1:OW]),
    .buf_data_i  (buf_data),
    .buf_valid_i (buf_valid),
    .rd_addr_i   (ptr_q),
    .rd_data_o   (rd_data)
  );

  seeprom_prog_timer #(.T_PROG(T_PROG)) u_timer (
    .clk_i, .rst_ni, .start_i(commit), .busy_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      sda_oe_q  <= 1'b0;
    end else if (bus_ev.start) begin
      sda_oe_q  <= 1'b0;
      bit_cnt_q <= '0;
      state_q   <= busy_o ? ST_SKIP : ST_DEV;
    end else if (bus_ev.stop) begin
      sda_oe_q  <= 1'b0;
      state_q   <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (bus_ev.scl_rise) begin
            shreg_q <= byte_now[6:0];
            if (!byte_done) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (state_q == ST_DEV) begin
              if (byte_now[7:1] == DEV_ADDR) begin
                state_q <= ST_ACK_WAIT;
                nxt_q   <= byte_now[0] ? ST_RD : ST_WADDR;
              end else begin
                state_q <= ST_SKIP;
              end
            end else if (state_q == ST_WADDR) begin
              ptr_q   <= byte_now[AW-1:0];
              state_q <= ST_ACK_WAIT;
              nxt_q   <= ST_WDATA;
            end else begin
              // page-local increment, upper bits fixed
              ptr_q[OW-1:0] <= ptr_q[OW-1:0] + 1'b1;
              state_q       <= ST_ACK_WAIT;
              nxt_q         <= ST_WDATA;
            end
          end
        end
        ST_ACK_WAIT: begin
          if (bus_ev.scl_fall) begin
            sda_oe_q <= 1'b1;
            state_q  <= ST_ACK_HOLD;
          end
        end
        ST_ACK_HOLD: begin
          if (bus_ev.scl_fall) begin
            bit_cnt_q <= '0;
            state_q   <= nxt_q;
            if (nxt_q == ST_RD) begin
              tx_q     <= rd_data;
              sda_oe_q <= ~rd_data[7];
            end else begin
              sda_oe_q <= 1'b0;
            end
          end
        end
        ST_RD: begin
          if (bus_ev.scl_rise) begin
            if (byte_done) begin
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RD_ACK;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end else if (bus_ev.scl_fall) begin
            sda_oe_q <= ~tx_q[3'd7 - bit_cnt_q];
          end
        end
        ST_RD_ACK: begin
          if (bus_ev.scl_fall) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_RD_ACKS;
          end
        end
        ST_RD_ACKS: begin
          if (bus_ev.scl_rise) state_q <= bus_ev.sda ? ST_SKIP : ST_RD_NEXT;
        end
        ST_RD_NEXT: begin
          if (bus_ev.scl_fall) begin
            tx_q      <= rd_data;
            sda_oe_q  <= ~rd_data[7];
            bit_cnt_q <= '0;
            state_q   <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_o = sda_oe_q;
endmodule

// File: rtl/seeprom_target_chk.sv
module seeprom_target_chk #(
  parameter int T_PROG = 200
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_fall_s,
  input logic stop_s,
  input logic wp_i,
  input logic sda_o,
  input logic busy_o
);
  int unsigned busy_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run_q <= 0;
    else if (busy_o) busy_run_q <= busy_run_q + 1;
    else             busy_run_q <= 0;
  end

  assert_drive_after_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_o != $past(sda_o)) |-> $past(scl_fall_s));

  assert_busy_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_s));

  assert_busy_length_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_run_q == T_PROG));

  assert_silent_when_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_o);

  assert_protect_no_prog_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(wp_i));
endmodule

bind seeprom_target seeprom_target_chk #(.T_PROG(T_PROG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_fall_s (bus_ev.scl_fall),
  .stop_s     (bus_ev.stop),
  .wp_i       (wp_i),
  .sda_o      (sda_o),
  .busy_o     (busy_o)
);

// File: tb/seeprom_target_tb_top.sv
module seeprom_target_tb_top;
  localparam int TP = 600;
  localparam int Q  = 16;
  localparam logic [6:0] DEV = 7'h50;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_o, busy_o;
  wire  sda_line = sda_m & ~sda_o;

  always #4 clk_i = ~clk_i;

  seeprom_target #(.T_PROG(TP)) dut_i (
    .clk_i, .rst_ni, .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp), .sda_o, .busy_o
  );

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int stop_at = -100000;
  bit mon_en = 1'b0;
  logic [7:0] ref_mem [128];
  logic [6:0] ref_ptr;
  logic [7:0] pbuf [16];
  logic [15:0] pval;

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit exp_busy();
    return (cyc >= stop_at + 3) && (cyc < stop_at + 3 + TP);
  endfunction

  // R6 R7 R8: busy compared on every clock
  always @(negedge clk_i) if (mon_en) chk(busy_o == exp_busy(), "R6", busy_o, exp_busy());

  task automatic hw(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hw(Q);
    scl_m = 1'b1; hw(Q);
    sda_m = 1'b0; pval = '0; hw(Q);
    scl_m = 1'b0; hw(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hw(Q);
    scl_m = 1'b1; hw(Q);
    sda_m = 1'b1;
    if (pval != '0 && !wp && !exp_busy()) begin
      stop_at = cyc;
      for (int i = 0; i < 16; i++)
        if (pval[i]) ref_mem[{ref_ptr[6:4], 4'(i)}] = pbuf[i];
    end
    pval = '0;
    hw(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(Q);
      scl_m = 1'b1; hw(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hw(Q);
    scl_m = 1'b1; hw(Q/2);
    ack = !sda_line; hw(Q/2);
    scl_m = 1'b0;
  endtask

  task automatic read_byte(bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(Q);
      scl_m = 1'b1; hw(Q/2);
      b[i] = sda_line; hw(Q/2);
      scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; hw(Q);
    scl_m = 1'b1; hw(Q);
    scl_m = 1'b0;
  endtask

  task automatic m_data(logic [7:0] b);
    pbuf[ref_ptr[3:0]] = b;
    pval[ref_ptr[3:0]] = 1'b1;
    ref_ptr = {ref_ptr[6:4], ref_ptr[3:0] + 4'd1};
  endtask

  task automatic addr_phase(logic [6:0] a);
    bit ack;
    i2c_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R1", ack, 1);
    send_byte({1'b0, a}, ack);   chk(ack, "R3", ack, 1);
    ref_ptr = a;
  endtask

  task automatic write_seq(logic [6:0] a, logic [7:0] d [$]);
    bit ack;
    addr_phase(a);
    foreach (d[i]) begin
      send_byte(d[i], ack); chk(ack, "R4", ack, 1);
      m_data(d[i]);
    end
    i2c_stop();
  endtask

  task automatic read_seq(logic [6:0] a, int n, string req);
    bit ack;
    logic [7:0] b;
    addr_phase(a);
    i2c_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R10", ack, 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i < n - 1, b);
      chk(b == ref_mem[ref_ptr], req, b, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 7'd1;
    end
    i2c_stop();
  endtask

  task automatic poll(bit exp_ack, string req);
    bit ack;
    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack == exp_ack, req, ack, exp_ack);
    i2c_stop();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] q [$];
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
    pval = '0;
    ref_ptr = '0;
    hw(5);
    rst_ni = 1'b1;
    hw(2);
    chk(busy_o == 1'b0, "R11", busy_o, 0);
    chk(sda_o == 1'b0, "R11", sda_o, 0);
    mon_en = 1'b1;
    read_seq(7'h00, 2, "R11");

    // single byte, then address polling
    write_seq(7'h05, '{8'hA5});
    hw(20);
    poll(1'b0, "R7");
    hw(TP);
    poll(1'b1, "R7");
    read_seq(7'h04, 3, "R3");

    // page wrap inside one page
    q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    write_seq(7'h1C, q);
    hw(TP + 20);
    read_seq(7'h10, 16, "R4");

    // more than a page of data in one write
    q = {};
    for (int i = 0; i < 18; i++) q.push_back(8'(8'h80 + i));
    write_seq(7'h30, q);
    hw(TP + 20);
    read_seq(7'h30, 16, "R5");

    // write protect
    wp = 1'b1;
    write_seq(7'h40, '{8'h01, 8'h02, 8'h03});
    hw(40);
    wp = 1'b0;
    read_seq(7'h40, 3, "R8");

    // foreign device address
    i2c_start();
    send_byte({7'h51, 1'b0}, ack); chk(!ack, "R2", ack, 0);
    send_byte(8'h20, ack);         chk(!ack, "R2", ack, 0);
    send_byte(8'hEE, ack);         chk(!ack, "R2", ack, 0);
    i2c_stop();
    hw(40);
    read_seq(7'h20, 1, "R2");

    // repeated START discards staged bytes, keeps pointer
    addr_phase(7'h60);
    send_byte(8'h12, ack); chk(ack, "R9", ack, 1); m_data(8'h12);
    send_byte(8'h34, ack); chk(ack, "R9", ack, 1); m_data(8'h34);
    i2c_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R9", ack, 1);
    read_byte(1'b0, b);
    chk(b == ref_mem[ref_ptr], "R9", b, ref_mem[ref_ptr]);
    i2c_stop();
    hw(TP + 20);
    read_seq(7'h60, 2, "R9");

    // sequential read across the top of the array
    write_seq(7'h7E, '{8'hC1, 8'hC2});
    hw(TP + 20);
    write_seq(7'h00, '{8'hC3});
    hw(TP + 20);
    read_seq(7'h7E, 4, "R10");

    hw(20);
    finish_run();
  end
endmodule